// File: doc/BRIEF.md
# Fractional-Edge PWM Output Stage

This block is a two-channel PWM output stage built on an up-counting time base. Channel A is high while the counter is below the A compare, and channel B is high while it is below the B compare. A fine-edge fraction is written into a shadow register. It is copied into an active register on a selectable counter event. When that copy happens, a fine-edge offset is registered. The offset is either the fraction scaled by an 8-bit step factor or the fraction as written, for the case where software has already scaled it.

A downstream fine-delay stage receives a rising-edge offset and a falling-edge offset. An edge-mode field selects which of the two carry the offset. A routing stage at the pins can replace B with the inverse of A. It can then swap the two outputs.

Configuration is written through one control port, `ctrl_wr_i`/`ctrl_wdata_i`, and takes effect on the next clock. The step factor is written through `step_wr_i`/`step_wdata_i`. The fraction shadow is written through `frac_wr_i`/`frac_wdata_i`. The period and the compare values are plain inputs.

Top module: `pwm_fine_edge_stage`

## Requirements
- R1: After reset the counter is 0 and every register is 0: control, step factor, shadow fraction, active fraction and offset. Both offset outputs are therefore 0, and routing is straight-through.
- R2: The counter advances by one per clock. When it is at or above `period_i` it returns to 0 on the next clock. `pwm_a_o` is 1 exactly while the counter is below `cmp_a_i`, provided swap and inversion are off.
- R3: When the inversion bit is 0, channel B is 1 exactly while the counter is below `cmp_b_i`.
- R4: Load select is control bits [3:2]. Code 00 copies the shadow into the active register on the clock at which the counter is 0. Code 01 copies it on the clock at which the counter equals `period_i`. Code 10 copies it on either event. The copy takes the shadow value held before that clock.
- R5: Load-select code 11 never copies the shadow. The offset outputs keep their value whatever is written to the shadow or the step factor.
- R6: Auto-conversion is control bit [4]. When it is 1, the offset loaded is the upper 8 bits of the 16-bit product of the shadow fraction and the step factor. When it is 0, the offset loaded is the shadow fraction unchanged.
- R7: The offset changes only on a load event. Writes to the step factor or the shadow between loads leave it unchanged.
- R8: Edge mode is control bits [1:0]. Code 00 drives both offset outputs to 0. Code 01 puts the offset on `rise_off_o` only. Code 10 puts it on `fall_off_o` only. Code 11 puts it on both.
- R9: When control bit [5] is 1, channel B is the logical inverse of channel A.
- R10: When control bit [6] is 1, channel B appears on `pwm_a_o` and channel A on `pwm_b_o`. The swap is applied after the B inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | 16 | Counter period (last count before wrap) |
| cmp_a_i | input | 16 | Channel A compare |
| cmp_b_i | input | 16 | Channel B compare |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 7 | Control value: [1:0] edge mode, [3:2] load select, [4] auto-convert, [5] B inversion, [6] swap |
| step_wr_i | input | 1 | Step factor write strobe |
| step_wdata_i | input | 8 | Step factor value |
| frac_wr_i | input | 1 | Shadow fraction write strobe |
| frac_wdata_i | input | 8 | Shadow fraction value |
| pwm_a_o | output | 1 | Output pin A |
| pwm_b_o | output | 1 | Output pin B |
| rise_off_o | output | 8 | Fine offset for the rising edge |
| fall_off_o | output | 8 | Fine offset for the falling edge |

## Verification
The pin outputs depend combinationally on the registered counter and the registered control. They are therefore due in the same cycle as the clock edge that moves the counter or commits a control write. The offsets appear one clock after the load edge, and that edge uses the shadow, step and control values held before it.

The bench keeps a cycle model that it advances once per rising edge, using the inputs driven for that edge. It drives inputs and compares all four outputs at the falling edge, halfway between two updates. Each result is therefore checked in the first cycle it is due.

// File: rtl/pwm_fine_pkg.sv
package pwm_fine_pkg;
  typedef enum logic [1:0] {
    LD_ZERO = 2'b00,
    LD_PRD  = 2'b01,
    LD_BOTH = 2'b10,
    LD_NONE = 2'b11
  } load_sel_e;

  typedef enum logic [1:0] {
    EM_OFF  = 2'b00,
    EM_RISE = 2'b01,
    EM_FALL = 2'b10,
    EM_BOTH = 2'b11
  } edge_mode_e;

  // bit order matches ctrl_wdata_i
  typedef struct packed {
    logic       swap;
    logic       b_inv;
    logic       auto_conv;
    load_sel_e  load_sel;
    edge_mode_e edge_mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_time_base.sv
module pwm_time_base #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             prd_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q >= period_i) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign prd_o  = (cnt_q == period_i);
endmodule

// File: rtl/pwm_frac_shadow.sv
module pwm_frac_shadow
  import pwm_fine_pkg::*;
#(
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FRAC_W-1:0] wdata_i,
  input  logic [FRAC_W-1:0] step_i,
  input  logic              auto_i,
  input  load_sel_e         load_sel_i,
  input  logic              zero_i,
  input  logic              prd_i,
  output logic [FRAC_W-1:0] act_o,
  output logic [FRAC_W-1:0] off_o,
  output logic              load_o
);
  localparam int PROD_W = 2 * FRAC_W;

  logic [FRAC_W-1:0] shadow_q, act_q, off_q, off_next;
  logic [PROD_W-1:0] prod;
  logic              load;

  always_comb begin
    unique case (load_sel_i)
      LD_ZERO: load = zero_i;
      LD_PRD:  load = prd_i;
      LD_BOTH: load = zero_i | prd_i;
      default: load = 1'b0;
    endcase
  end

  assign prod     = PROD_W'(shadow_q) * PROD_W'(step_i);
  assign off_next = auto_i ? prod[PROD_W-1:FRAC_W] : shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
      off_q    <= '0;
    end else begin
      if (wr_i) shadow_q <= wdata_i;
      if (load) begin
        act_q <= shadow_q;
        off_q <= off_next;
      end
    end
  end

  assign act_o  = act_q;
  assign off_o  = off_q;
  assign load_o = load;
endmodule

// File: rtl/pwm_out_route.sv
module pwm_out_route
  import pwm_fine_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_a_i,
  input  logic [CNT_W-1:0]  cmp_b_i,
  input  logic [FRAC_W-1:0] off_i,
  input  edge_mode_e        edge_mode_i,
  input  logic              b_inv_i,
  input  logic              swap_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic [FRAC_W-1:0] rise_off_o,
  output logic [FRAC_W-1:0] fall_off_o
);
  logic              ch_a, ch_b;
  logic [1:0]        mode_bits;
  logic [FRAC_W-1:0] edge_off [2];

  assign ch_a = (cnt_i < cmp_a_i);
  assign ch_b = b_inv_i ? ~ch_a : (cnt_i < cmp_b_i);

  assign pwm_a_o = swap_i ? ch_b : ch_a;
  assign pwm_b_o = swap_i ? ch_a : ch_b;

  assign mode_bits = edge_mode_i;

  // index 0 = rising, 1 = falling
  for (genvar e = 0; e < 2; e++) begin : g_edge
    assign edge_off[e] = mode_bits[e] ? off_i : '0;
  end

  assign rise_off_o = edge_off[0];
  assign fall_off_o = edge_off[1];
endmodule

// File: rtl/pwm_fine_edge_stage.sv
module pwm_fine_edge_stage
  import pwm_fine_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  cmp_a_i,
  input  logic [CNT_W-1:0]  cmp_b_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              step_wr_i,
  input  logic [FRAC_W-1:0] step_wdata_i,
  input  logic              frac_wr_i,
  input  logic [FRAC_W-1:0] frac_wdata_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic [FRAC_W-1:0] rise_off_o,
  output logic [FRAC_W-1:0] fall_off_o
);
  ctrl_t             ctrl_q;
  logic [FRAC_W-1:0] step_q;
  logic [CNT_W-1:0]  cnt;
  logic              zero_evt, prd_evt, load_evt;
  logic [FRAC_W-1:0] act_frac, edge_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      step_q <= '0;
    end else begin
      if (ctrl_wr_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
      if (step_wr_i) step_q <= step_wdata_i;
    end
  end

  pwm_time_base #(.CNT_W(CNT_W)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .cnt_o   (cnt),
    .zero_o  (zero_evt),
    .prd_o   (prd_evt)
  );

  pwm_frac_shadow #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (frac_wr_i),
    .wdata_i   (frac_wdata_i),
    .step_i    (step_q),
    .auto_i    (ctrl_q.auto_conv),
    .load_sel_i(ctrl_q.load_sel),
    .zero_i    (zero_evt),
    .prd_i     (prd_evt),
    .act_o     (act_frac),
    .off_o     (edge_off),
    .load_o    (load_evt)
  );

  pwm_out_route #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_route (
    .cnt_i      (cnt),
    .cmp_a_i    (cmp_a_i),
    .cmp_b_i    (cmp_b_i),
    .off_i      (edge_off),
    .edge_mode_i(ctrl_q.edge_mode),
    .b_inv_i    (ctrl_q.b_inv),
    .swap_i     (ctrl_q.swap),
    .pwm_a_o    (pwm_a_o),
    .pwm_b_o    (pwm_b_o),
    .rise_off_o (rise_off_o),
    .fall_off_o (fall_off_o)
  );
endmodule

// File: rtl/pwm_fine_edge_checker.sv
module pwm_fine_edge_checker #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  period_i,
  input logic [1:0]        edge_mode,
  input logic [1:0]        load_sel,
  input logic              b_inv,
  input logic              swap,
  input logic              load_evt,
  input logic [FRAC_W-1:0] act_frac,
  input logic [FRAC_W-1:0] edge_off,
  input logic              pwm_a_o,
  input logic              pwm_b_o,
  input logic [FRAC_W-1:0] rise_off_o,
  input logic [FRAC_W-1:0] fall_off_o
);
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt >= period_i) |=> (cnt == '0)); // R2

  AST_RSV_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_sel == 2'b11) |=> $stable(act_frac)); // R5

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_evt |=> $stable(edge_off)); // R7

  AST_EDGE_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode == 2'b00) |-> (rise_off_o == '0 && fall_off_o == '0)); // R8

  AST_B_INVERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_inv && !swap) |-> (pwm_b_o == !pwm_a_o)); // R9

  AST_SWAP_INVERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_inv && swap) |-> (pwm_a_o == !pwm_b_o)); // R10
endmodule

bind pwm_fine_edge_stage pwm_fine_edge_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt       (cnt),
  .period_i  (period_i),
  .edge_mode (ctrl_q.edge_mode),
  .load_sel  (ctrl_q.load_sel),
  .b_inv     (ctrl_q.b_inv),
  .swap      (ctrl_q.swap),
  .load_evt  (load_evt),
  .act_frac  (act_frac),
  .edge_off  (edge_off),
  .pwm_a_o   (pwm_a_o),
  .pwm_b_o   (pwm_b_o),
  .rise_off_o(rise_off_o),
  .fall_off_o(fall_off_o)
);

// File: tb/tb_pwm_fine_edge_stage.sv
`timescale 1ns/1ps
module tb_pwm_fine_edge_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = '0, cmp_a = '0, cmp_b = '0;
  logic        ctrl_wr = 1'b0, step_wr = 1'b0, frac_wr = 1'b0;
  logic [6:0]  ctrl_wd = '0;
  logic [7:0]  step_wd = '0, frac_wd = '0;
  logic        pwm_a, pwm_b;
  logic [7:0]  rise_off, fall_off;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_cnt;
  logic [6:0]  m_ctrl;
  logic [7:0]  m_step, m_shadow, m_off;

  always #2 clk = ~clk;

  pwm_fine_edge_stage dut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wd), .step_wr_i(step_wr), .step_wdata_i(step_wd),
    .frac_wr_i(frac_wr), .frac_wdata_i(frac_wd),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .rise_off_o(rise_off), .fall_off_o(fall_off)
  );

  function automatic logic [7:0] scaled(input logic [7:0] f, input logic [7:0] s);
    logic [15:0] p;
    p = {8'b0, f} * {8'b0, s};
    return p[15:8];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic ea, eb, ra, rb;
    ea = (m_cnt < cmp_a);
    eb = m_ctrl[5] ? !ea : (m_cnt < cmp_b);
    ra = m_ctrl[6] ? eb : ea;
    rb = m_ctrl[6] ? ea : eb;
    chk(m_ctrl[6] ? "R10 pin A" : "R2 pin A", {15'b0, pwm_a}, {15'b0, ra});
    chk(m_ctrl[6] ? "R10 pin B" : (m_ctrl[5] ? "R9 pin B" : "R3 pin B"), {15'b0, pwm_b}, {15'b0, rb});
    chk("R4 R5 R6 R7 R8 rise offset", {8'b0, rise_off}, {8'b0, m_ctrl[0] ? m_off : 8'h00});
    chk("R4 R5 R6 R7 R8 fall offset", {8'b0, fall_off}, {8'b0, m_ctrl[1] ? m_off : 8'h00});
  endtask

  // apply one rising edge to the model using the currently driven inputs
  task automatic model_edge();
    logic ld;
    case (m_ctrl[3:2])
      2'b00:   ld = (m_cnt == 16'd0);
      2'b01:   ld = (m_cnt == period);
      2'b10:   ld = (m_cnt == 16'd0) || (m_cnt == period);
      default: ld = 1'b0;
    endcase
    if (ld) m_off = m_ctrl[4] ? scaled(m_shadow, m_step) : m_shadow;
    if (frac_wr) m_shadow = frac_wd;
    if (ctrl_wr) m_ctrl = ctrl_wd;
    if (step_wr) m_step = step_wd;
    m_cnt = (m_cnt >= period) ? 16'd0 : m_cnt + 16'd1;
  endtask

  // called at a falling edge with inputs already set
  task automatic cycle();
    model_edge();
    @(negedge clk);
    check_outputs();
    ctrl_wr = 1'b0; step_wr = 1'b0; frac_wr = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [6:0] v);
    ctrl_wr = 1'b1; ctrl_wd = v; cycle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_cnt = '0; m_ctrl = '0; m_step = '0; m_shadow = '0; m_off = '0;
    period = 16'd5; cmp_a = 16'd2; cmp_b = 16'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state visible at the ports
    chk("R1 pin A", {15'b0, pwm_a}, 16'd1);
    chk("R1 pin B", {15'b0, pwm_b}, 16'd1);
    chk("R1 rise offset", {8'b0, rise_off}, 16'd0);
    chk("R1 fall offset", {8'b0, fall_off}, 16'd0);
    repeat (12) cycle();  // R2 wrap at period 5

    // R1: step factor reset 0 -> auto-scaled offset is 0
    wr_ctrl(7'b001_00_11);
    frac_wr = 1'b1; frac_wd = 8'hC8; cycle();
    repeat (8) cycle();
    chk("R1 R6 step reset scaled offset", {8'b0, rise_off}, 16'd0);

    // R6 manual pass-through, load on period
    wr_ctrl(7'b000_01_11);
    repeat (8) cycle();
    chk("R6 manual offset", {8'b0, rise_off}, 16'h00C8);

    // R5: reserved load code, shadow and step writes must not reach offset
    wr_ctrl(7'b001_11_11);
    step_wr = 1'b1; step_wd = 8'hFF; cycle();
    frac_wr = 1'b1; frac_wd = 8'h11; cycle();
    repeat (15) cycle();
    chk("R5 reserved load keeps offset", {8'b0, fall_off}, 16'h00C8);

    // R6 auto: 0x11*0xFF>>8 = 0x10, load on both events
    wr_ctrl(7'b001_10_01);
    repeat (8) cycle();
    chk("R6 auto scaled offset", {8'b0, rise_off}, 16'h0010);

    // R9, R10 directed
    wr_ctrl(7'b010_00_10);
    repeat (8) cycle();
    wr_ctrl(7'b110_00_10);
    repeat (8) cycle();
    wr_ctrl(7'b100_00_00);
    repeat (8) cycle();

    // period 0 corner
    period = 16'd0;
    repeat (4) cycle();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) period = 16'($urandom_range(0, 9));
      if ($urandom_range(0, 7) == 0)  cmp_a  = 16'($urandom_range(0, 11));
      if ($urandom_range(0, 7) == 0)  cmp_b  = 16'($urandom_range(0, 11));
      if ($urandom_range(0, 19) == 0) begin ctrl_wr = 1'b1; ctrl_wd = 7'($urandom); end
      if ($urandom_range(0, 9) == 0)  begin step_wr = 1'b1; step_wd = 8'($urandom); end
      if ($urandom_range(0, 4) == 0)  begin frac_wr = 1'b1; frac_wd = 8'($urandom); end
      cycle();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule